// File: doc/BRIEF.md
# Amplifier Supervisory Sequencer

This block decides when a switching audio output stage may run. Once reset is released it looks at the power-good flag. Only when that flag is high and no fault flag is raised does it begin a long settling interval. By default the interval is two seconds, and its length in cycles is derived from the clock frequency. When the interval ends, the sequencer enables audio sampling and the output stage together.

Five fault flags are watched in every active state:
- over-voltage
- over-current
- over-temperature
- a switching failure of either transistor
- DC present at the speaker

If any of them rises, the sequencer trips. Sampling stops and both power switches are forced off. A five-bit code records which flags caused the trip. The trip is latched. It ends only when a restart request arrives while every fault flag is low. The sequencer then returns to the power check and runs the full settling interval again. If power-good drops while settling or running, the sequence also restarts from the power check.

Top module: `amp_supervisor`

## Requirements
- R1: While `rst` is high, `sample_en` and `stage_en` are low and `fault_code` is zero.
- R2: After reset, with `pwr_ok` low and no fault flag set, both enables stay low indefinitely.
- R3: The settling interval starts at the first clock edge that sees `pwr_ok` high with no fault. The enables rise exactly SETTLE_CYCLES edges after that edge and not before.
- R4: In the running state, `sample_en` and `stage_en` are both high and `fault_code` is zero.
- R5: A fault flag seen at any clock edge outside the tripped state trips the sequencer. From the next cycle both enables are low and `fault_code` holds the flags seen at that edge, with bit 0 over-voltage, bit 1 over-current, bit 2 over-temperature, bit 3 switching failure and bit 4 DC.
- R6: While tripped, `fault_code` keeps every bit it already holds and gains the bit of any flag that rises later.
- R7: A restart request (`clr`) while any fault flag is high has no effect. A restart request with all fault flags low leaves the trip: `fault_code` returns to zero and the power check and the full settling interval follow.
- R8: If `pwr_ok` falls while settling or running, the enables go or stay low from the next cycle with no fault recorded. A later start needs the full settling interval again.
- R9: A fault flag that rises during the settling interval trips the sequencer, and running never begins.
- R10: By default SETTLE_CYCLES equals CLK_HZ multiplied by SETTLE_SEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_ok | input | 1 | Supply rails good |
| flt_overvolt | input | 1 | Over-voltage flag |
| flt_overcur | input | 1 | Over-current flag |
| flt_overtemp | input | 1 | Over-temperature flag |
| flt_switch | input | 1 | Power switch failure flag |
| flt_dc | input | 1 | DC-at-speaker flag |
| clr | input | 1 | Restart request after a trip |
| sample_en | output | 1 | Audio sampling enable |
| stage_en | output | 1 | Output stage (both switches) enable |
| fault_code | output | 5 | Latched trip cause, bit per flag |

## Verification
The properties assume that `pwr_ok`, `clr` and the five fault flags are already synchronous to `clk`, because they compare flags against the code one edge later. The bench drives every input only on the falling edge, so each flag is steady across the rising edge that samples it. Fault flags are applied only for whole clock cycles, and the restart request is raised only while the sequencer is tripped or idle in the power check.

// File: rtl/amp_sup_pkg.sv
`timescale 1ns/1ps
package amp_sup_pkg;

  localparam int FLT_W = 5;

  localparam int FB_OVERVOLT = 0;
  localparam int FB_OVERCUR  = 1;
  localparam int FB_OVERTEMP = 2;
  localparam int FB_SWITCH   = 3;
  localparam int FB_DC       = 4;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_PWRCHK = 3'd1,
    ST_SETTLE = 3'd2,
    ST_RUN    = 3'd3,
    ST_TRIP   = 3'd4
  } sup_state_e;

  function automatic logic [FLT_W-1:0] pack_faults(input logic ov, input logic oc,
                                                   input logic ot, input logic sw,
                                                   input logic dc);
    logic [FLT_W-1:0] v;
    v = '0;
    v[FB_OVERVOLT] = ov;
    v[FB_OVERCUR]  = oc;
    v[FB_OVERTEMP] = ot;
    v[FB_SWITCH]   = sw;
    v[FB_DC]       = dc;
    return v;
  endfunction

  function automatic int settle_length(input int clk_hz, input int seconds);
    return clk_hz * seconds;
  endfunction

endpackage

// File: rtl/sup_settle_timer.sv
`timescale 1ns/1ps
module sup_settle_timer #(
  parameter int SETTLE_CYCLES = 16,
  localparam int CW = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == CW'(SETTLE_CYCLES - 1));
endmodule

// File: rtl/sup_fault_latch.sv
`timescale 1ns/1ps
module sup_fault_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         hold,
  input  logic [W-1:0] flags,
  output logic [W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst)          code <= '0;
    else if (capture) code <= (hold ? code : '0) | flags;
    else              code <= '0;
  end
endmodule

// File: rtl/sup_seq_fsm.sv
`timescale 1ns/1ps
module sup_seq_fsm
  import amp_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_ok,
  input  logic       fault_any,
  input  logic       clr,
  input  logic       settle_done,
  output sup_state_e state,
  output sup_state_e state_nx
);
  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RESET:  state_nx = fault_any ? ST_TRIP : ST_PWRCHK;
      ST_PWRCHK: begin
        if (fault_any)   state_nx = ST_TRIP;
        else if (pwr_ok) state_nx = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (fault_any)        state_nx = ST_TRIP;
        else if (!pwr_ok)     state_nx = ST_PWRCHK;
        else if (settle_done) state_nx = ST_RUN;
      end
      ST_RUN: begin
        if (fault_any)    state_nx = ST_TRIP;
        else if (!pwr_ok) state_nx = ST_PWRCHK;
      end
      ST_TRIP: if (clr && !fault_any) state_nx = ST_PWRCHK;
      default: state_nx = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= state_nx;
  end
endmodule

// File: rtl/amp_supervisor.sv
`timescale 1ns/1ps
module amp_supervisor
  import amp_sup_pkg::*;
#(
  parameter int CLK_HZ        = 125_000_000,
  parameter int SETTLE_SEC    = 2,
  parameter int SETTLE_CYCLES = settle_length(CLK_HZ, SETTLE_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_ok,
  input  logic             flt_overvolt,
  input  logic             flt_overcur,
  input  logic             flt_overtemp,
  input  logic             flt_switch,
  input  logic             flt_dc,
  input  logic             clr,
  output logic             sample_en,
  output logic             stage_en,
  output logic [FLT_W-1:0] fault_code
);
  logic [FLT_W-1:0] flags;
  logic             fault_any;
  logic             settle_done;
  logic             in_settle;
  logic             entering_trip;
  logic             in_trip;
  sup_state_e       state;
  sup_state_e       state_nx;

  assign flags     = pack_faults(flt_overvolt, flt_overcur, flt_overtemp, flt_switch, flt_dc);
  assign fault_any = |flags;

  sup_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pwr_ok      (pwr_ok),
    .fault_any   (fault_any),
    .clr         (clr),
    .settle_done (settle_done),
    .state       (state),
    .state_nx    (state_nx)
  );

  assign in_settle     = (state == ST_SETTLE);
  assign in_trip       = (state == ST_TRIP);
  assign entering_trip = (state_nx == ST_TRIP);

  sup_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (in_settle),
    .done (settle_done)
  );

  sup_fault_latch #(.W(FLT_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (entering_trip),
    .hold    (in_trip),
    .flags   (flags),
    .code    (fault_code)
  );

  assign sample_en = (state == ST_RUN);
  assign stage_en  = (state == ST_RUN);
endmodule

// File: rtl/amp_supervisor_chk.sv
`timescale 1ns/1ps
module amp_supervisor_chk #(
  parameter int SETTLE_CYCLES = 16,
  localparam int CW = $clog2(SETTLE_CYCLES + 2)
) (
  input logic       clk,
  input logic       rst,
  input logic       pwr_ok,
  input logic [4:0] flags,
  input logic       clr,
  input logic       sample_en,
  input logic       stage_en,
  input logic [4:0] fault_code,
  input logic       in_settle
);
  logic [CW-1:0] wcnt;
  always_ff @(posedge clk) begin
    if (rst || !in_settle) wcnt <= '0;
    else                   wcnt <= wcnt + 1'b1;
  end

  p_trip_blanks_r5: assert property (@(posedge clk) disable iff (rst)
    (|flags) |=> (!sample_en && !stage_en));

  p_code_covers_r5: assert property (@(posedge clk) disable iff (rst)
    (|flags) |=> ((fault_code & $past(flags)) == $past(flags)));

  p_code_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (fault_code != 5'd0 && !clr) |=> ((fault_code & $past(fault_code)) == $past(fault_code)));

  p_clear_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (fault_code != 5'd0 && (|flags)) |=> (fault_code != 5'd0));

  p_run_needs_power_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_en) |-> ($past(pwr_ok) && !$past(|flags)));

  p_power_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !pwr_ok) |=> !sample_en);

  p_settle_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_en) |-> (wcnt == CW'(SETTLE_CYCLES)));

  p_run_clean_r4: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> (stage_en && fault_code == 5'd0));
endmodule

bind amp_supervisor amp_supervisor_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_ok     (pwr_ok),
  .flags      (flags),
  .clr        (clr),
  .sample_en  (sample_en),
  .stage_en   (stage_en),
  .fault_code (fault_code),
  .in_settle  (in_settle)
);

// File: tb/amp_supervisor_test.sv
`timescale 1ns/1ps
module amp_supervisor_test;
  localparam int HZ = 10;
  localparam int SEC = 2;
  localparam int N = 20; // independent restatement: 10 Hz * 2 s (R10)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0;
  logic [4:0] fl = 5'd0; // [0] ov, [1] oc, [2] ot, [3] switch, [4] dc
  logic clr = 1'b0;
  logic sample_en, stage_en;
  logic [4:0] fault_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  amp_supervisor #(.CLK_HZ(HZ), .SETTLE_SEC(SEC)) uut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
    .flt_overvolt(fl[0]), .flt_overcur(fl[1]), .flt_overtemp(fl[2]),
    .flt_switch(fl[3]), .flt_dc(fl[4]), .clr(clr),
    .sample_en(sample_en), .stage_en(stage_en), .fault_code(fault_code)
  );

  typedef struct {
    logic       s;
    logic       g;
    logic [4:0] c;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic step(input logic p, input logic [4:0] f, input logic c,
                      input logic on, input logic [4:0] code, input string tag);
    exp_t e;
    @(negedge clk);
    pwr_ok = p; fl = f; clr = c;
    e.s = on; e.g = on; e.c = code; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle_full(input string tag);
    for (int i = 0; i < N; i++) step(1'b1, 5'd0, 1'b0, 1'b0, 5'd0, tag);
    step(1'b1, 5'd0, 1'b0, 1'b1, 5'd0, tag);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sample_en !== e.s || stage_en !== e.g || fault_code !== e.c) begin
        fails++;
        $display("FAIL %s: got sample=%b stage=%b code=%05b, expected sample=%b stage=%b code=%05b",
                 e.tag, sample_en, stage_en, fault_code, e.s, e.g, e.c);
      end
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1'b0, 5'd0, 1'b0, 1'b0, 5'd0, "R1 reset quiet");
    rst = 1'b0;
    for (int i = 0; i < 6; i++) step(1'b0, 5'd0, 1'b0, 1'b0, 5'd0, "R2 no power no start");
    settle_full("R3 R10 settle length");
    for (int i = 0; i < 3; i++) step(1'b1, 5'd0, 1'b0, 1'b1, 5'd0, "R4 running");
    step(1'b1, 5'b00010, 1'b0, 1'b0, 5'b00010, "R5 over-current trip");
    for (int i = 0; i < 3; i++) step(1'b1, 5'd0, 1'b0, 1'b0, 5'b00010, "R6 code latched");
    step(1'b1, 5'b10000, 1'b1, 1'b0, 5'b10010, "R7 clear blocked, R6 code grows");
    step(1'b1, 5'd0, 1'b0, 1'b0, 5'b10010, "R6 code held");
    step(1'b1, 5'd0, 1'b1, 1'b0, 5'd0, "R7 clear accepted");
    settle_full("R7 full restart");
    step(1'b1, 5'b01001, 1'b0, 1'b0, 5'b01001, "R5 two flags at once");
    step(1'b1, 5'd0, 1'b1, 1'b0, 5'd0, "R7 clear");
    for (int i = 0; i < 6; i++) step(1'b1, 5'd0, 1'b0, 1'b0, 5'd0, "R9 settling");
    step(1'b1, 5'b00100, 1'b0, 1'b0, 5'b00100, "R9 trip during settle");
    for (int i = 0; i < N + 2; i++) step(1'b1, 5'd0, 1'b0, 1'b0, 5'b00100, "R9 never runs");
    step(1'b0, 5'd0, 1'b1, 1'b0, 5'd0, "R7 clear to power check");
    for (int i = 0; i < 5; i++) step(1'b1, 5'd0, 1'b0, 1'b0, 5'd0, "R8 settling");
    step(1'b0, 5'd0, 1'b0, 1'b0, 5'd0, "R8 power lost in settle");
    step(1'b0, 5'd0, 1'b0, 1'b0, 5'd0, "R8 idle");
    settle_full("R8 full interval again");
    step(1'b0, 5'd0, 1'b0, 1'b0, 5'd0, "R8 power lost while running");
    step(1'b0, 5'b00001, 1'b0, 1'b0, 5'b00001, "R5 over-voltage in power check");
    step(1'b0, 5'd0, 1'b1, 1'b0, 5'd0, "R7 clear");
    settle_full("R3 restart after clear");
    step(1'b1, 5'b01000, 1'b0, 1'b0, 5'b01000, "R5 switch failure");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule